// File: doc/BRIEF.md
# Text-Mode Character Pixel Renderer

This block turns a raster position into one pixel colour for an 80 by 25 character display. Each cell is 8 pixels wide and 16 lines tall, so the text area is 640 by 400 pixels. For every pixel clock the block reads the character code stored for the current cell from a text buffer. It then looks up one glyph row for that code and picks one bit from it. A set bit gives the foreground colour and a clear bit gives the background colour. Both colours are single global 12-bit inputs, with 4 bits for each of red, green and blue, packed as {red, green, blue}.

The text buffer has two clocks. A processor fills it through a write-only port that runs on its own write clock. The pixel side reads it on the pixel clock. At power-up the buffer already holds a short preset message. Sync generation and the processor bus are outside this block. The block delays the incoming sync and active flags so that they stay aligned with the pixel they belong to.

The raster side works like a stream with no back-pressure. One position is accepted on every pixel clock, and one pixel leaves on every clock, two cycles later. There is no ready signal, because a display scan cannot stall. The write port is a plain strobe, and every write is accepted in the cycle it is presented.

Top module: `text_pixel_render`

## Requirements
- R1: While rst_n is low, rgb_out is 0, active_out is 0, hsync_out is 0 and vsync_out is 0.
- R2: For a pixel at (x, y), the cell column is x/8 and the cell row is y/16. The buffer cell is row*80 + column.
- R3: Within a glyph row byte, the pixel at x%8 = 0 uses bit 7, and the pixel at x%8 = 7 uses bit 0.
- R4: For an active pixel, rgb_out equals fg_color when the selected glyph bit is 1, and bg_color when it is 0.
- R5: The glyph row for code c at line r = y%16 is c XOR (r << 4) when c is in 0x21..0x7E and r is in 2..13. In every other case it is 0x00.
- R6: When the active flag presented two cycles earlier was 0, rgb_out is 0, whatever the glyph bit is.
- R7: rgb_out, active_out, hsync_out and vsync_out show the result for the inputs presented two pixel clocks earlier.
- R8: A write with wr_en high on a wr_clk rising edge stores wr_char into cell wr_addr when wr_addr < 2000. A write with wr_addr >= 2000 changes no cell.
- R9: At power-up, cells 0..9 hold "TEXT READY" in ASCII (0x54 0x45 0x58 0x54 0x20 0x52 0x45 0x41 0x44 0x59). Every other cell holds 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pixel pipeline |
| wr_clk | input | 1 | Clock of the processor write port |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 11 | Cell index of the write |
| wr_char | input | 8 | Character code to store |
| pix_x | input | 10 | Horizontal raster position |
| pix_y | input | 10 | Vertical raster position |
| pix_active | input | 1 | Position is inside the visible area |
| hsync_in | input | 1 | Horizontal sync, passed through in step with the pixel |
| vsync_in | input | 1 | Vertical sync, passed through in step with the pixel |
| fg_color | input | 12 | Foreground colour {r,g,b} |
| bg_color | input | 12 | Background colour {r,g,b} |
| rgb_out | output | 12 | Pixel colour |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |
| active_out | output | 1 | Delayed active flag |

## Verification
The bench builds the block with its default parameters: an 80 by 25 grid, 8 by 16 cells and 12-bit colour. With these values the last cell (1999) and the first write address past the grid (2000) are both real values on the 11-bit write port. The bench scans complete pixel lines of cell rows 0, 12 and 24, so the right edge at x = 639 and the bottom line at y = 399 are reached. Out-of-range writes at 2000 and 2047 fall where a wrongly masked or truncated address would land in a scanned row.

// File: rtl/text_render_pkg.sv
package text_render_pkg;

  // Glyph row generator: printable codes get a pattern on lines 2..13.
  function automatic logic [7:0] glyph_row(input logic [7:0] code, input logic [3:0] line);
    logic printable;
    logic body;
    printable = (code >= 8'h21) && (code <= 8'h7E);
    body      = (line >= 4'd2) && (line <= 4'd13);
    if (printable && body) return code ^ {line, 4'h0};
    return 8'h00;
  endfunction

  // Power-up content: a short banner at the top-left corner, spaces elsewhere.
  function automatic logic [7:0] boot_char(input int idx);
    case (idx)
      0: return 8'h54;
      1: return 8'h45;
      2: return 8'h58;
      3: return 8'h54;
      4: return 8'h20;
      5: return 8'h52;
      6: return 8'h45;
      7: return 8'h41;
      8: return 8'h44;
      9: return 8'h59;
      default: return 8'h20;
    endcase
  endfunction

endpackage

// File: rtl/pipe_delay.sv
module pipe_delay #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [N-1:0][W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < N; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[N-1];
endmodule

// File: rtl/text_buffer.sv
module text_buffer
  import text_render_pkg::*;
#(
  parameter int DEPTH  = 2000,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(boot_char(i));
  end

  // Write side: processor clock, cells past the grid are dropped.
  always_ff @(posedge wr_clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
  end

  // Read side: pixel clock, one cycle of latency.
  always_ff @(posedge rd_clk) begin
    if (rd_en && (int'(rd_addr) < DEPTH)) rd_data <= mem[rd_addr];
    else                                  rd_data <= '0;
  end
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom
  import text_render_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] code,
  input  logic [3:0] line,
  output logic [7:0] row_bits
);
  always_ff @(posedge clk) begin
    row_bits <= glyph_row(code, line);
  end

  p_blank_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(code) < 8'h21) || ($past(code) > 8'h7E)) |-> (row_bits == 8'h00));

  p_blank_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(line) < 4'd2) || ($past(line) > 4'd13)) |-> (row_bits == 8'h00));
endmodule

// File: rtl/text_pixel_render.sv
module text_pixel_render #(
  parameter int COLS    = 80,
  parameter int ROWS    = 25,
  parameter int CELL_W  = 8,
  parameter int CELL_H  = 16,
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int CHAR_W  = 8,
  parameter int COLOR_W = 12,
  parameter int ADDR_W  = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CHAR_W-1:0]  wr_char,
  input  logic [X_W-1:0]     pix_x,
  input  logic [Y_W-1:0]     pix_y,
  input  logic               pix_active,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic [COLOR_W-1:0] fg_color,
  input  logic [COLOR_W-1:0] bg_color,
  output logic [COLOR_W-1:0] rgb_out,
  output logic               hsync_out,
  output logic               vsync_out,
  output logic               active_out
);
  localparam int CELLS  = COLS * ROWS;
  localparam int XLO_W  = $clog2(CELL_W);
  localparam int YLO_W  = $clog2(CELL_H);
  localparam int COL_W  = X_W - XLO_W;
  localparam int ROW_W  = Y_W - YLO_W;
  localparam int FULL_W = X_W + Y_W;
  localparam int CTRL_W = 3 + XLO_W;
  localparam logic [XLO_W-1:0] LAST_PX = XLO_W'(CELL_W - 1);

  // Stage 0: cell address from the raster position.
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [FULL_W-1:0] cell_full;
  logic              in_grid;
  logic [ADDR_W-1:0] rd_addr;

  assign col       = pix_x[X_W-1:XLO_W];
  assign row       = pix_y[Y_W-1:YLO_W];
  assign cell_full = FULL_W'(row) * FULL_W'(COLS) + FULL_W'(col);
  assign in_grid   = (int'(col) < COLS) && (cell_full < FULL_W'(CELLS));
  assign rd_addr   = in_grid ? cell_full[ADDR_W-1:0] : '0;

  // Stage 1: character code out of the buffer.
  logic [CHAR_W-1:0] char_q;

  text_buffer #(
    .DEPTH (CELLS),
    .ADDR_W(ADDR_W),
    .DATA_W(CHAR_W)
  ) u_buf (
    .wr_clk (wr_clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_char),
    .rd_clk (clk),
    .rd_en  (in_grid),
    .rd_addr(rd_addr),
    .rd_data(char_q)
  );

  logic [YLO_W-1:0] line_q;

  pipe_delay #(.W(YLO_W), .N(1)) u_line_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pix_y[YLO_W-1:0]),
    .q    (line_q)
  );

  // Stage 2: glyph row out of the font.
  logic [CHAR_W-1:0] glyph_q;

  glyph_rom u_font (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (char_q),
    .line    (line_q),
    .row_bits(glyph_q)
  );

  logic [CTRL_W-1:0] ctrl_in, ctrl_q;
  logic [XLO_W-1:0]  px_q;
  logic              act_q, hs_q, vs_q;

  assign ctrl_in = {pix_active, hsync_in, vsync_in, pix_x[XLO_W-1:0]};

  pipe_delay #(.W(CTRL_W), .N(2)) u_ctrl_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctrl_in),
    .q    (ctrl_q)
  );

  assign {act_q, hs_q, vs_q, px_q} = ctrl_q;

  // Output: bit pick (leftmost pixel = MSB), colour choice, blanking.
  logic [XLO_W-1:0] bit_idx;
  logic             ink;

  assign bit_idx = LAST_PX - px_q;
  assign ink     = glyph_q[bit_idx];

  always_comb begin
    if (!act_q)   rgb_out = '0;
    else if (ink) rgb_out = fg_color;
    else          rgb_out = bg_color;
  end

  assign hsync_out  = hs_q;
  assign vsync_out  = vs_q;
  assign active_out = act_q;

  // Cycles since reset, used only to keep $past windows inside reset history.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm <= '0;
    else if (warm != 2'd2)   warm <= warm + 2'd1;
  end

  p_ctrl_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> ((hsync_out == $past(hsync_in, 2)) &&
                        (vsync_out == $past(vsync_in, 2)) &&
                        (active_out == $past(pix_active, 2))));

  p_blank_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm == 2'd2) && !$past(pix_active, 2)) |-> (rgb_out == '0));

  p_colour_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_out |-> ((rgb_out == fg_color) || (rgb_out == bg_color)));

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (rgb_out == '0 && !active_out && !hsync_out && !vsync_out);
    end
  end
endmodule

// File: tb/text_pixel_render_test.sv
module text_pixel_render_test;
  logic        clk = 0, wr_clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [10:0] wr_addr = 0;
  logic [7:0]  wr_char = 0;
  logic [9:0]  pix_x = 0, pix_y = 0;
  logic        pix_active = 0, hsync_in = 0, vsync_in = 0;
  logic [11:0] fg_color = 12'hF80, bg_color = 12'h00F;
  logic [11:0] rgb_out;
  logic        hsync_out, vsync_out, active_out;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R9 preset";

  typedef struct { int x; int y; bit a; bit h; bit v; } ent_t;
  ent_t q[$];
  byte unsigned model [2000];

  always #2 clk = ~clk;
  always #3.5 wr_clk = ~wr_clk;

  text_pixel_render uut (
    .clk(clk), .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_char(wr_char), .pix_x(pix_x), .pix_y(pix_y), .pix_active(pix_active),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .fg_color(fg_color), .bg_color(bg_color),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out), .active_out(active_out)
  );

  function automatic int font_of(int c, int ln);
    if (c >= 'h21 && c <= 'h7E && ln >= 2 && ln <= 13) return (c ^ (ln * 16)) & 'hFF;
    return 0;
  endfunction

  function automatic logic [11:0] expect_rgb(ent_t e);
    int c, g, b;
    if (!e.a) return 12'h000;
    c = model[(e.y / 16) * 80 + (e.x / 8)];
    g = font_of(c, e.y % 16);
    b = (g >> (7 - (e.x % 8))) & 1;
    return (b != 0) ? fg_color : bg_color;
  endfunction

  task automatic check_entry(ent_t e);
    logic [11:0] er;
    er = expect_rgb(e);
    tests++;
    if (rgb_out !== er || active_out !== e.a || hsync_out !== e.h || vsync_out !== e.v) begin
      fails++;
      $display("FAIL %s %s x=%0d y=%0d actual rgb=%h act=%b hs=%b vs=%b expected rgb=%h act=%b hs=%b vs=%b",
               e.a ? "R2 R3 R4 R5 R7" : "R6 R7", phase, e.x, e.y,
               rgb_out, active_out, hsync_out, vsync_out, er, e.a, e.h, e.v);
    end
  endtask

  task automatic pix(int x, int y, bit a, bit h, bit v);
    ent_t e;
    @(negedge clk);
    if (q.size() == 2) check_entry(q.pop_front());
    pix_x = 10'(x); pix_y = 10'(y); pix_active = a; hsync_in = h; vsync_in = v;
    e.x = x; e.y = y; e.a = a; e.h = h; e.v = v;
    q.push_back(e);
  endtask

  task automatic scan_cell_row(int r);
    for (int ln = 0; ln < 16; ln++) begin
      for (int x = 0; x < 640; x++) pix(x, r * 16 + ln, 1, 0, (ln == 0));
      for (int k = 0; k < 16; k++) pix(640 + k, r * 16 + ln, 0, (k >= 4 && k < 12), 0);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge wr_clk);
    wr_en = 1; wr_addr = 11'(a); wr_char = 8'(d);
    @(negedge wr_clk);
    wr_en = 0;
    if (a < 2000) model[a] = 8'(d);
  endtask

  initial begin
    for (int i = 0; i < 2000; i++) model[i] = 8'h20;
    model[0] = 8'h54; model[1] = 8'h45; model[2] = 8'h58; model[3] = 8'h54;
    model[4] = 8'h20; model[5] = 8'h52; model[6] = 8'h45; model[7] = 8'h41;
    model[8] = 8'h44; model[9] = 8'h59;

    // R1: reset state with busy inputs
    pix_active = 1; hsync_in = 1; vsync_in = 1; pix_x = 10'd5; pix_y = 10'd3;
    repeat (4) @(negedge clk);
    tests++; if (rgb_out !== 12'h000) begin fails++; $display("FAIL R1 rgb actual=%h expected=000", rgb_out); end
    tests++; if (active_out !== 1'b0) begin fails++; $display("FAIL R1 active actual=%b expected=0", active_out); end
    tests++; if (hsync_out !== 1'b0) begin fails++; $display("FAIL R1 hsync actual=%b expected=0", hsync_out); end
    tests++; if (vsync_out !== 1'b0) begin fails++; $display("FAIL R1 vsync actual=%b expected=0", vsync_out); end
    pix_active = 0; hsync_in = 0; vsync_in = 0;
    @(negedge clk); rst_n = 1;

    // R9: preset banner on the top cell row
    phase = "R9 preset";
    scan_cell_row(0);
    pix(0, 0, 0, 0, 0); pix(0, 0, 0, 0, 0);

    // R8: writes, including the edges of the grid and past it
    wr(0, 'h41); wr(79, 'h7E); wr(80, 'h21); wr(1999, 'h5A);
    wr(1000, 'h7F); wr(976, 'h4D);
    wr(2000, 'h51); wr(2047, 'h52);
    repeat (4) pix(0, 0, 0, 0, 0);

    phase = "R8 written";
    fg_color = 12'h0F0; bg_color = 12'hAAA;
    scan_cell_row(0);
    scan_cell_row(12);
    scan_cell_row(24);
    scan_cell_row(5);

    phase = "random";
    fg_color = 12'h123; bg_color = 12'hEDC;
    for (int i = 0; i < 3000; i++)
      pix($urandom_range(639), $urandom_range(399), 1'($urandom_range(1)),
          1'($urandom_range(1)), 1'($urandom_range(1)));
    pix(0, 0, 0, 0, 0); pix(0, 0, 0, 0, 0); pix(0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule